// File: doc/BRIEF.md
# Serial Jump-Condition Register Writer

This block is the write port through which a microcontroller loads the 8-bit external condition register of a DSP sequencer. The controller frames a transfer by pulling the request line low and clocks sixteen bits on the serial data pin with the serial clock. The first byte is a command code and the second byte is the new condition value. Both bytes go most significant bit first. All of these pins, and the audio frame clock, are synchronized into the system clock before any edge is detected. The frame clock is taken as a level, so it is not used as a clock.

A complete and valid transfer does not change the register at once. The value is parked, and the ready output drops to show that the port is busy. The register is written on the next active edge of the frame clock. That edge is the rising one in normal mode and the falling one when the I2S-compatible phase is selected. Ready then returns high. Any transfer the controller attempts while ready is low is thrown away. A transfer with the wrong command byte is also thrown away, and so is one cut short by the request line.

The jump-taken output is combinational. It is high when some bit is set both in the condition register and in the condition field of the current instruction.

The control state machine has three states:
- ST_IDLE: ready is high and the receiver is armed.
- ST_HOLD: ready is low and the value waits for the commit edge.
- ST_LOAD: ready is low and the register is written.

Its transitions are:
- T_FRAME: ST_IDLE to ST_HOLD, when a complete, valid frame is received.
- T_EDGE: ST_HOLD to ST_LOAD, on the commit edge of the frame clock.
- T_DONE: ST_LOAD to ST_IDLE, unconditionally after one cycle.

Top module: `jump_cond_writer`

## Requirements
- R1: After reset, `cond_value` is 0x00, `rdy` is 1 and `jump_taken` is 0 for any `ifcon`.
- R2: A frame is 16 bits sent while `rq_n` is low. `si` is sampled on each rising edge of `sclk`, MSB first. The first byte must be 0xC4 and the second byte is the data. After the commit, `cond_value` equals the data byte.
- R3: `rdy` goes low no more than 6 system clocks after the 16th rising `sclk` edge of a valid frame.
- R4: With `i2s_mode`=0, `cond_value` keeps its old value and `rdy` stays low until a rising edge of `lrclk`. A falling edge of `lrclk` does not commit.
- R5: With `i2s_mode`=1, a falling edge of `lrclk` commits. A rising edge does not commit, and `rdy` stays low after it.
- R6: `rdy` returns to 1 no more than 8 system clocks after the commit edge. At that point `cond_value` already holds the new value.
- R7: While `rdy` is 0, a complete frame sent by the controller has no effect. After the pending commit, `cond_value` holds the first value, and later edges leave it there.
- R8: A frame whose first byte is not 0xC4 is discarded. `rdy` stays 1 throughout and `cond_value` is unchanged, even across `lrclk` edges.
- R9: If `rq_n` returns high before 16 bits have been received, nothing is updated and `rdy` stays 1. The next full frame is received normally.
- R10: `jump_taken` is 1 exactly when `cond_value & ifcon` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller; SI is sampled on its rising edge |
| si | input | 1 | Serial data in, MSB first |
| rq_n | input | 1 | Active-low transfer request, framing a write |
| lrclk | input | 1 | Audio frame clock, used as the commit strobe |
| i2s_mode | input | 1 | 1 selects the falling frame-clock edge as the commit edge |
| ifcon | input | 8 | Condition field of the current instruction |
| rdy | output | 1 | 1 when the port accepts a write; 0 while a commit is pending |
| jump_taken | output | 1 | OR reduction of `cond_value & ifcon` |
| cond_value | output | 8 | Current content of the external condition register |

## Verification
The assertions take three things for granted:
- The serial clock, frame clock and request line change slowly enough that every level lasts several system clocks.
- `si` is steady around each rising edge of `sclk`.
- `i2s_mode` changes only while the port is idle and the frame clock is still.

The stimulus drives every pin on the falling system-clock edge. It holds each serial clock phase for at least four clocks and moves the mode pin only while ready is high. It toggles the frame clock by hand, one edge at a time, so that every commit edge is one the bench chose.

// File: rtl/jcw_pkg.sv
package jcw_pkg;

    localparam int unsigned JCW_BYTE_W    = 8;
    localparam int unsigned JCW_SYNC_DEPTH = 2;
    localparam logic [JCW_BYTE_W-1:0] JCW_CMD_CODE = 8'hC4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOAD = 2'd2
    } jcw_state_e;

endpackage

// File: rtl/jcw_sync.sv
module jcw_sync #(
    parameter int unsigned N       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign level[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/jcw_edge.sv
module jcw_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic sel_fall,
    output logic pulse
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level;
        end
    end

    always_comb begin
        if (sel_fall) begin
            pulse = prev_q & ~level;
        end else begin
            pulse = level & ~prev_q;
        end
    end

endmodule

// File: rtl/jcw_shift_rx.sv
module jcw_shift_rx #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] CMD = 8'hC4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         rq_low,
    input  logic         bit_strobe,
    input  logic         bit_val,
    output logic         frame_done,
    output logic [W-1:0] frame_data
);

    localparam int unsigned FRAME_BITS = 2 * W;
    localparam int unsigned CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST_CMD_BIT = CW'(W - 1);
    localparam logic [CW-1:0] LAST_BIT     = CW'(FRAME_BITS - 1);

    logic          armed_q;
    logic          discard_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  shreg_q;
    logic          done_q;
    logic [W-1:0]  next_shreg;

    assign next_shreg = {shreg_q[W-2:0], bit_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            discard_q <= 1'b0;
            cnt_q     <= '0;
            shreg_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable) begin
                armed_q   <= 1'b0;
                discard_q <= 1'b0;
                cnt_q     <= '0;
            end else if (!rq_low) begin
                armed_q   <= 1'b1;
                discard_q <= 1'b0;
                cnt_q     <= '0;
            end else if (armed_q && !discard_q && bit_strobe) begin
                shreg_q <= next_shreg;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST_CMD_BIT && next_shreg != CMD) begin
                    discard_q <= 1'b1;
                end
                if (cnt_q == LAST_BIT) begin
                    done_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign frame_done = done_q;
    assign frame_data = shreg_q;

endmodule

// File: rtl/jcw_ctrl.sv
module jcw_ctrl
    import jcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic commit_edge,
    output logic rdy,
    output logic cap_en,
    output logic load_en
);

    jcw_state_e state_q;
    jcw_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_done)  state_d = ST_HOLD;
            ST_HOLD: if (commit_edge) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rdy     = 1'b0;
        cap_en  = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rdy    = 1'b1;
                cap_en = frame_done;
            end
            ST_HOLD: begin
                rdy = 1'b0;
            end
            ST_LOAD: begin
                load_en = 1'b1;
            end
            default: begin
                rdy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/jcw_match.sv
module jcw_match #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cond,
    input  logic [W-1:0] field,
    output logic         taken
);

    assign taken = |(cond & field);

endmodule

// File: rtl/jump_cond_writer.sv
module jump_cond_writer
    import jcw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  si,
    input  logic                  rq_n,
    input  logic                  lrclk,
    input  logic                  i2s_mode,
    input  logic [JCW_BYTE_W-1:0] ifcon,
    output logic                  rdy,
    output logic                  jump_taken,
    output logic [JCW_BYTE_W-1:0] cond_value
);

    localparam int unsigned NSYNC = 4;
    localparam int unsigned IX_SCLK = 0;
    localparam int unsigned IX_SI   = 1;
    localparam int unsigned IX_RQ   = 2;
    localparam int unsigned IX_LR   = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

    logic [NSYNC-1:0]      raw_in;
    logic [NSYNC-1:0]      sync_lvl;
    logic                  sclk_rise;
    logic                  commit_edge;
    logic                  frame_done;
    logic [JCW_BYTE_W-1:0] frame_data;
    logic                  cap_en;
    logic                  load_en;
    logic [JCW_BYTE_W-1:0] pending_q;
    logic [JCW_BYTE_W-1:0] cond_q;

    assign raw_in = {lrclk, rq_n, si, sclk};

    jcw_sync #(
        .N       (NSYNC),
        .STAGES  (JCW_SYNC_DEPTH),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .level (sync_lvl)
    );

    jcw_edge #(.RST_VAL(1'b0)) i_sclk_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_lvl[IX_SCLK]),
        .sel_fall (1'b0),
        .pulse    (sclk_rise)
    );

    jcw_edge #(.RST_VAL(1'b0)) i_lr_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_lvl[IX_LR]),
        .sel_fall (i2s_mode),
        .pulse    (commit_edge)
    );

    jcw_shift_rx #(
        .W   (JCW_BYTE_W),
        .CMD (JCW_CMD_CODE)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rdy),
        .rq_low     (~sync_lvl[IX_RQ]),
        .bit_strobe (sclk_rise),
        .bit_val    (sync_lvl[IX_SI]),
        .frame_done (frame_done),
        .frame_data (frame_data)
    );

    jcw_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .commit_edge (commit_edge),
        .rdy         (rdy),
        .cap_en      (cap_en),
        .load_en     (load_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            cond_q    <= '0;
        end else begin
            if (cap_en) begin
                pending_q <= frame_data;
            end
            if (load_en) begin
                cond_q <= pending_q;
            end
        end
    end

    jcw_match #(.W(JCW_BYTE_W)) i_match (
        .cond  (cond_q),
        .field (ifcon),
        .taken (jump_taken)
    );

    assign cond_value = cond_q;

endmodule

// File: rtl/jcw_checker.sv
module jcw_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rdy,
    input logic         jump_taken,
    input logic [W-1:0] cond_value,
    input logic [W-1:0] ifcon,
    input logic         frame_done,
    input logic         commit_edge
);

    p_fall_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(frame_done));

    p_update_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cond_value) |-> $past(!rdy));

    p_rise_after_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(commit_edge, 2));

    p_no_frame_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !frame_done);

    p_jump_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_value != '0 && ifcon == {W{1'b1}}) |-> jump_taken);

    p_jump_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_value == '0) |-> !jump_taken);

endmodule

bind jump_cond_writer jcw_checker #(.W(8)) i_chk (.*);

// File: tb/test_jump_cond_writer.sv
module test_jump_cond_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic       rq_n = 1'b1;
    logic       lrclk = 1'b0;
    logic       i2s_mode = 1'b0;
    logic [7:0] ifcon = 8'h00;
    logic       rdy;
    logic       jump_taken;
    logic [7:0] cond_value;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  seen_low;
    logic last_hi_rdy;

    always #2 clk = ~clk;

    jump_cond_writer i_jump_cond_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .si         (si),
        .rq_n       (rq_n),
        .lrclk      (lrclk),
        .i2s_mode   (i2s_mode),
        .ifcon      (ifcon),
        .rdy        (rdy),
        .jump_taken (jump_taken),
        .cond_value (cond_value)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rdy) seen_low = 1'b1;
        end
    endtask

    task automatic send(input logic [7:0] cmd, input logic [7:0] dat, input int nbits);
        seen_low = 1'b0;
        @(negedge clk);
        rq_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            si = (i < 8) ? cmd[7-i] : dat[15-i];
            tick(4);
            sclk = 1'b1;
            tick(6);
            last_hi_rdy = rdy;
        end
        sclk = 1'b0;
        tick(4);
        rq_n = 1'b1;
        tick(4);
    endtask

    task automatic commit(input string req);
        logic target;
        target = ~i2s_mode;
        if (lrclk == target) begin
            lrclk = ~lrclk;
            tick(8);
            check(rdy == 1'b0, req, rdy, 0);
        end
        lrclk = ~lrclk;
        tick(8);
    endtask

    task automatic both_edges();
        lrclk = ~lrclk;
        tick(8);
        lrclk = ~lrclk;
        tick(8);
    endtask

    task automatic jump_probe(input logic [7:0] f, input logic [7:0] c);
        ifcon = f;
        #1;
        check(jump_taken == |(c & f), "R10", jump_taken, |(c & f));
    endtask

    initial begin
        logic [7:0] prev;
        logic [7:0] bad;
        prev = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(4);
        ifcon = 8'hFF;
        #1;
        check(rdy == 1'b1, "R1", rdy, 1);
        check(cond_value == 8'h00, "R1", cond_value, 0);
        check(jump_taken == 1'b0, "R1", jump_taken, 0);

        for (int d = 0; d < 256; d++) begin
            i2s_mode = d[0];
            tick(2);
            send(8'hC4, d[7:0], 16);
            check(last_hi_rdy == 1'b0, "R3", last_hi_rdy, 0);
            tick(20);
            check(rdy == 1'b0, "R4", rdy, 0);
            check(cond_value == prev, "R4", cond_value, prev);
            commit(d[0] ? "R5" : "R4");
            check(rdy == 1'b1, "R6", rdy, 1);
            check(cond_value == d[7:0], "R2", cond_value, d);
            jump_probe(8'h00, d[7:0]);
            for (int k = 0; k < 8; k++) jump_probe(8'(1 << k), d[7:0]);
            prev = d[7:0];
        end

        i2s_mode = 1'b0;
        tick(2);
        for (int k = 0; k < 8; k++) begin
            bad = 8'hC4 ^ 8'(1 << k);
            send(bad, 8'h3C, 16);
            tick(10);
            both_edges();
            check(seen_low == 1'b0, "R8", seen_low, 0);
            check(cond_value == prev, "R8", cond_value, prev);
        end

        send(8'hC4, 8'h81, 4);
        both_edges();
        check(seen_low == 1'b0, "R9", seen_low, 0);
        check(cond_value == prev, "R9", cond_value, prev);
        send(8'hC4, 8'h81, 15);
        both_edges();
        check(seen_low == 1'b0, "R9", seen_low, 0);
        check(cond_value == prev, "R9", cond_value, prev);
        send(8'hC4, 8'h81, 16);
        commit("R4");
        check(cond_value == 8'h81, "R9", cond_value, 8'h81);

        send(8'hC4, 8'h5A, 16);
        send(8'hC4, 8'hA5, 16);
        check(rdy == 1'b0, "R7", rdy, 0);
        commit("R4");
        check(cond_value == 8'h5A, "R7", cond_value, 8'h5A);
        both_edges();
        both_edges();
        check(cond_value == 8'h5A, "R7", cond_value, 8'h5A);
        check(rdy == 1'b1, "R7", rdy, 1);

        for (int f = 0; f < 256; f++) jump_probe(f[7:0], 8'h5A);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule